// File: doc/BRIEF.md
# SPI Status Autopoll Engine

This engine sits beside an SPI master and waits on a device status byte so that software does not have to. Once started, it runs a loop of short SPI frames. In each frame it sends a one-byte command, reads back one response byte, and tests a single chosen bit of that response against an expected level. The loop stops on the first match, or when a retry budget runs out, or when software stops it. Each outcome is reported in its own interrupt status bit. A typical use is waiting until a flash memory clears its write-in-progress bit, or sets its write-enable latch.

Software starts a run with one write to a 32-bit control word. The word holds the command byte, the bit position, the expected level, a 4-bit timeout exponent and a start/busy flag. The serial clock rate select input also scales the retry budget: the budget is 31 shifted left by the sum of that select and the timeout field. A small status unit holds three write-one-to-clear flags. These are try finished, poll success and poll timeout. Through a mask, all three drive one interrupt line.

Top module: `spi_autopoll`

## Requirements
- R1: Control word layout: command in bits 7:0, timeout in 19:16, bit position in 26:24, expected level in bit 30, start/busy in bit 31. A write while idle loads all fields. The readback returns these fields and returns 0 in every other bit.
- R2: A write with bit 31 = 1 while idle sets readback bit 31 from the next cycle. Chip select (active low) falls two cycles after the write edge.
- R3: Each try is one frame. Chip select goes low, and 8 command bits go out MSB first, changing while SCK is low. Then 8 response bits are sampled MSB first on SCK rising edges. Chip select then stays high for at least one SCK period. Each SCK level lasts 2^div_sel_i clock cycles, and SCK toggles only while chip select is low.
- R4: When response bit [position] equals the expected level, polling ends after that try. Status bit 1 (success) is set and readback bit 31 clears.
- R5: The try limit is 31 << min(div_sel_i + timeout, 15). After that many non-matching tries, status bit 2 (timeout) is set and readback bit 31 clears.
- R6: Status bit 0 is set at the end of every try.
- R7: Writing bit 31 = 0 while busy ends polling after the current try. Neither bit 1 nor bit 2 is set, even if that try matches.
- R8: Writes with bit 31 = 1 while busy are ignored. The fields and the command sent keep their values.
- R9: Writing 1 to a status bit through the acknowledge port clears it. A set and a clear of the same bit in the same cycle leave the bit at 1.
- R10: irq_o is 1 exactly when some status bit is 1 and its mask bit is 0.
- R11: After reset the readback and the status are 0, chip select is high, SCK is low and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word write data |
| ctrl_rdata_o | output | 32 | Control word readback, bit 31 = busy |
| div_sel_i | input | 3 | Clock rate select: SCK half period 2^n cycles, also scales try limit |
| irq_mask_i | input | 3 | Per-bit interrupt mask, 1 = suppressed |
| irq_ack_we_i | input | 1 | Acknowledge strobe |
| irq_ack_i | input | 3 | Write-one-to-clear pattern for status |
| irq_stat_o | output | 3 | Status: bit 0 try done, bit 1 success, bit 2 timeout |
| irq_o | output | 1 | Combined interrupt line |
| sck_o | output | 1 | SPI serial clock (idle low) |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to device |
| miso_i | input | 1 | SPI data from device |

## Verification
The status unit can be asked to set and to clear the same flag in one cycle. This happens when a try ends, or the run ends, while software is writing ones to acknowledge. The bench provokes it by holding the acknowledge strobe with all ones through a full timeout run. Every try end and the final timeout then coincide with a clear. The check is that the try-done flag shows exactly one one-cycle pulse per try, that the timeout flag shows one pulse, and that both read 1 in the cycle the busy flag drops.

// File: rtl/spi_autopoll_pkg.sv
package spi_autopoll_pkg;
  localparam int CMD_LSB  = 0;
  localparam int TMO_LSB  = 16;
  localparam int POS_LSB  = 24;
  localparam int LVL_BIT  = 30;
  localparam int BUSY_BIT = 31;
  localparam int TMO_W    = 4;

  localparam int IRQ_XFER = 0;
  localparam int IRQ_OK   = 1;
  localparam int IRQ_TMO  = 2;
  localparam int IRQ_N    = 3;

  typedef struct packed {
    logic [7:0]       cmd;
    logic [TMO_W-1:0] tmo;
    logic [2:0]       pos;
    logic             lvl;
  } ap_cfg_t;
endpackage

// File: rtl/spi_ap_shifter.sv
module spi_ap_shifter #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       cmd_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       rx_o,
  output logic             sck_o,
  output logic             cs_no,
  output logic             mosi_o
);
  localparam int HC_W    = 2**DIV_W;
  localparam int PH_W    = 6;
  localparam int PH_BITS = 32;          // 16 bits x 2 halves
  localparam int PH_LAST = PH_BITS + 1; // two halves of deselect gap

  logic            act_q, done_q;
  logic [PH_W-1:0] ph_q;
  logic [HC_W-1:0] hc_q;
  logic [7:0]      rx_q;
  logic [HC_W-1:0] half_len;
  logic            half_end, frame;

  assign half_len = HC_W'(1) << div_i;
  assign half_end = (hc_q == half_len - 1'b1);
  assign frame    = act_q && (ph_q < PH_W'(PH_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= '0;
      hc_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start_i) begin
          act_q <= 1'b1;
          ph_q  <= '0;
          hc_q  <= '0;
        end
      end else if (half_end) begin
        hc_q <= '0;
        if (ph_q == PH_W'(PH_LAST)) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          ph_q <= ph_q + 1'b1;
          // rising SCK in response half of the frame
          if (frame && !ph_q[0] && ph_q[4]) rx_q <= {rx_q[6:0], miso_i};
        end
      end else begin
        hc_q <= hc_q + 1'b1;
      end
    end
  end

  assign busy_o = act_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sck_o  = frame && ph_q[0];
  assign cs_no  = !frame;
  assign mosi_o = (frame && !ph_q[4]) ? cmd_i[3'd7 - ph_q[3:1]] : 1'b0;

  // R3
  sck_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);
  // R3
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);
  // R3
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !act_q);
endmodule

// File: rtl/spi_ap_irq.sv
module spi_ap_irq #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q;
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_eff) | set_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ~mask_i);

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R9
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> stat_q[g]);
    // R9
    w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && clr_i[g] && !set_i[g]) |=> !stat_q[g]);
  end
endmodule

// File: rtl/spi_autopoll.sv
module spi_autopoll
  import spi_autopoll_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [31:0]      ctrl_wdata_i,
  output logic [31:0]      ctrl_rdata_o,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic [2:0]       irq_mask_i,
  input  logic             irq_ack_we_i,
  input  logic [2:0]       irq_ack_i,
  output logic [2:0]       irq_stat_o,
  output logic             irq_o,
  output logic             sck_o,
  output logic             cs_no,
  output logic             mosi_o,
  input  logic             miso_i
);
  localparam int SH_MAX = CNT_W - 5;   // 31 needs 5 bits
  localparam int SUM_W  = 6;

  ap_cfg_t          cfg_q;
  logic             busy_q, abort_q, kick_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, limit;
  logic [SUM_W-1:0] sh_sum, sh_amt;
  logic             sh_done, sh_busy, hit, wr_stop, go_on;
  logic [7:0]       sh_rx;
  logic [IRQ_N-1:0] irq_set;

  spi_ap_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(kick_q),
    .cmd_i  (cfg_q.cmd),
    .div_i  (div_sel_i),
    .miso_i (miso_i),
    .busy_o (sh_busy),
    .done_o (sh_done),
    .rx_o   (sh_rx),
    .sck_o  (sck_o),
    .cs_no  (cs_no),
    .mosi_o (mosi_o)
  );

  assign sh_sum  = SUM_W'(div_sel_i) + SUM_W'(cfg_q.tmo);
  assign sh_amt  = (sh_sum > SUM_W'(SH_MAX)) ? SUM_W'(SH_MAX) : sh_sum;
  assign limit   = CNT_W'(31) << sh_amt;
  assign cnt_nxt = cnt_q + 1'b1;
  assign hit     = (sh_rx[cfg_q.pos] == cfg_q.lvl);
  assign wr_stop = ctrl_we_i && !ctrl_wdata_i[BUSY_BIT] && busy_q;

  // abort outranks match, match outranks timeout
  always_comb begin
    irq_set = '0;
    go_on   = 1'b0;
    if (busy_q && sh_done) begin
      irq_set[IRQ_XFER] = 1'b1;
      if (abort_q || wr_stop)  irq_set = irq_set;
      else if (hit)            irq_set[IRQ_OK] = 1'b1;
      else if (cnt_nxt >= limit) irq_set[IRQ_TMO] = 1'b1;
      else                     go_on = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      busy_q  <= 1'b0;
      abort_q <= 1'b0;
      kick_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      kick_q <= 1'b0;
      if (!busy_q) begin
        if (ctrl_we_i) begin
          cfg_q.cmd <= ctrl_wdata_i[CMD_LSB +: 8];
          cfg_q.tmo <= ctrl_wdata_i[TMO_LSB +: TMO_W];
          cfg_q.pos <= ctrl_wdata_i[POS_LSB +: 3];
          cfg_q.lvl <= ctrl_wdata_i[LVL_BIT];
          busy_q    <= ctrl_wdata_i[BUSY_BIT];
          kick_q    <= ctrl_wdata_i[BUSY_BIT];
          cnt_q     <= '0;
          abort_q   <= 1'b0;
        end
      end else begin
        if (wr_stop) abort_q <= 1'b1;
        if (sh_done) begin
          cnt_q <= cnt_nxt;
          if (go_on) begin
            kick_q <= 1'b1;
          end else begin
            busy_q  <= 1'b0;
            abort_q <= 1'b0;
          end
        end
      end
    end
  end

  spi_ap_irq #(.N(IRQ_N)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (irq_set),
    .clr_we_i(irq_ack_we_i),
    .clr_i   (irq_ack_i),
    .mask_i  (irq_mask_i),
    .stat_o  (irq_stat_o),
    .irq_o   (irq_o)
  );

  always_comb begin
    ctrl_rdata_o                       = '0;
    ctrl_rdata_o[CMD_LSB +: 8]         = cfg_q.cmd;
    ctrl_rdata_o[TMO_LSB +: TMO_W]     = cfg_q.tmo;
    ctrl_rdata_o[POS_LSB +: 3]         = cfg_q.pos;
    ctrl_rdata_o[LVL_BIT]              = cfg_q.lvl;
    ctrl_rdata_o[BUSY_BIT]             = busy_q;
  end

  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[BUSY_BIT] && !busy_q) |=> ##1 !cs_no);
  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < limit));
  // R7
  end_after_try_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(sh_done));
  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(cfg_q));
  // R3
  no_frame_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !$past(busy_q)) |-> !sh_busy);
endmodule

// File: tb/spi_autopoll_bench.sv
module spi_autopoll_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic [2:0]  div_sel = '0;
  logic [2:0]  irq_mask = '0;
  logic        ack_we = 1'b0;
  logic [2:0]  ack = '0;
  logic [2:0]  irq_stat;
  logic        irq;
  logic        sck, cs_n, mosi;
  logic        miso = 1'b0;

  always #2.5ns clk = ~clk;   // 200 MHz

  spi_autopoll u_spi_autopoll (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .ctrl_rdata_o(ctrl_rdata), .div_sel_i(div_sel), .irq_mask_i(irq_mask),
    .irq_ack_we_i(ack_we), .irq_ack_i(ack), .irq_stat_o(irq_stat), .irq_o(irq),
    .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int       try_cnt = 0;
  int       dev_match = 0;
  int       dev_pos = 0;
  bit       dev_lvl = 1'b0;
  logic [7:0] exp_cmd = '0;
  logic [15:0] frame_bits;
  int       bitn = 0;
  logic [7:0] cap;
  int       cap_n = 0;

  always @(negedge cs_n) begin
    logic b;
    logic [7:0] resp;
    try_cnt++;
    b = (try_cnt == dev_match) ? dev_lvl : ~dev_lvl;
    resp = b ? (8'h1 << dev_pos) : ~(8'h1 << dev_pos);
    frame_bits = {8'h00, resp};
    bitn = 0;
    cap_n = 0;
    miso = frame_bits[15];
  end
  always @(negedge sck) begin
    if (!cs_n) begin
      bitn++;
      if (bitn < 16) miso = frame_bits[15 - bitn];
    end
  end
  always @(posedge sck) begin
    if (cap_n < 8) cap = {cap[6:0], mosi};
    cap_n++;
  end
  always @(posedge cs_n) begin
    if (rst_ni && cap_n == 16) chk(cap == exp_cmd, "R3 cmd on mosi", cap, exp_cmd);
  end

  // SCK high width in clock cycles, last completed pulse
  int hi_run = 0, hi_last = 0;
  always @(negedge clk) begin
    if (sck) hi_run++;
    else if (hi_run != 0) begin hi_last = hi_run; hi_run = 0; end
  end

  // ---------------- scoreboard ----------------
  typedef struct { int tries; logic [2:0] stat; string tag; } exp_t;
  exp_t sb_q[$];
  int n_push = 0, n_pop = 0;
  bit busy_prev = 1'b0;
  int pulse0 = 0, pulse2 = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (busy_prev && !ctrl_rdata[31]) begin
        if (sb_q.size() == 0) chk(1'b0, "scoreboard empty", 0, 1);
        else begin
          exp_t it;
          it = sb_q.pop_front();
          chk(try_cnt == it.tries, {it.tag, " tries"}, try_cnt, it.tries);
          chk(irq_stat == it.stat, {it.tag, " status"}, irq_stat, it.stat);
          chk(irq == 1'b1, "R10 line on end", irq, 1);
        end
        n_pop++;
      end
      busy_prev = ctrl_rdata[31];
      if (irq_stat[0]) pulse0++;
      if (irq_stat[2]) pulse2++;
    end
  end

  // ---------------- driver ----------------
  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    ack_we = 1'b1; ack = 3'b111;
    @(negedge clk);
    ack_we = 1'b0; ack = 3'b000;
  endtask

  function automatic logic [31:0] word(input logic [7:0] c, input logic [3:0] t,
                                       input logic [2:0] p, input bit l, input bit go);
    return {go, l, 3'b000, p, 4'h0, t, 8'h00, c};
  endfunction

  task automatic launch(input logic [7:0] c, input logic [3:0] t, input logic [2:0] p,
                        input bit l, input int match);
    dev_match = match; dev_pos = p; dev_lvl = l; exp_cmd = c; try_cnt = 0;
    wr(word(c, t, p, l, 1'b1));
  endtask

  task automatic push(input int tries, input logic [2:0] st, input string tag);
    exp_t it;
    it.tries = tries; it.stat = st; it.tag = tag;
    sb_q.push_back(it);
    n_push++;
  endtask

  task automatic wait_end();
    while (n_pop < n_push) @(negedge clk);
  endtask

  initial begin
    // watchdog
    #(200000 * 5ns);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(ctrl_rdata == 32'h0, "R11 readback", ctrl_rdata, 0);
    chk(irq_stat == 3'b000, "R11 status", irq_stat, 0);
    chk(cs_n == 1'b1 && sck == 1'b0, "R11 pins", {cs_n, sck}, 2'b10);
    chk(irq == 1'b0, "R11 irq", irq, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 idle write, unused bits read 0
    wr(32'h4F0A_00C3);
    chk(ctrl_rdata == 32'h470A_00C3, "R1 field readback", ctrl_rdata, 32'h470A_00C3);

    // R2 start: busy next cycle, cs low two edges after write
    dev_match = 2; dev_pos = 0; dev_lvl = 1'b0; exp_cmd = 8'h05; try_cnt = 0;
    push(2, 3'b011, "R4 R6 match level0");
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = word(8'h05, 4'h0, 3'd0, 1'b0, 1'b1);
    @(negedge clk);
    ctrl_we = 1'b0;
    chk(ctrl_rdata[31] == 1'b1, "R2 busy set", ctrl_rdata[31], 1);
    chk(cs_n == 1'b1, "R2 cs still high", cs_n, 1);
    @(negedge clk);
    chk(cs_n == 1'b0, "R2 cs low", cs_n, 0);
    wait_end();
    clear_all();

    // R4 match on third try, level 1, bit 3
    launch(8'hA7, 4'h0, 3'd3, 1'b1, 3);
    push(3, 3'b011, "R4 match try3");
    wait_end();
    clear_all();

    // R5 timeout, sel 0 tmo 0 -> 31 tries
    launch(8'h05, 4'h0, 3'd0, 1'b1, 0);
    push(31, 3'b101, "R5 timeout 31");
    wait_end();
    // R9 acknowledge only bit 2
    @(negedge clk);
    ack_we = 1'b1; ack = 3'b100;
    @(negedge clk);
    ack_we = 1'b0; ack = 3'b000;
    chk(irq_stat == 3'b001, "R9 w1c single bit", irq_stat, 3'b001);
    // R10 masking
    irq_mask = 3'b001;
    @(negedge clk);
    chk(irq == 1'b0, "R10 masked", irq, 0);
    irq_mask = 3'b010;
    @(negedge clk);
    chk(irq == 1'b1, "R10 unmasked bit", irq, 1);
    irq_mask = 3'b000;
    clear_all();
    chk(irq_stat == 3'b000, "R9 clear all", irq_stat, 0);

    // R5 sel 1 tmo 1 -> 124 tries, also R3 half period 2
    div_sel = 3'd1;
    launch(8'h3C, 4'h1, 3'd6, 1'b0, 0);
    push(124, 3'b101, "R5 timeout 124");
    wait_end();
    chk(hi_last == 2, "R3 sck high width sel1", hi_last, 2);
    clear_all();

    // R3 half period 4 with sel 2, match at first try
    div_sel = 3'd2;
    launch(8'h9F, 4'h3, 3'd1, 1'b1, 1);
    push(1, 3'b011, "R3 R4 sel2 match1");
    wait_end();
    chk(hi_last == 4, "R3 sck high width sel2", hi_last, 4);
    clear_all();
    div_sel = 3'd0;

    // R8 write while busy ignored
    launch(8'h05, 4'h0, 3'd2, 1'b1, 4);
    push(4, 3'b011, "R8 run");
    while (try_cnt < 2 || cs_n) @(negedge clk);
    wr(word(8'h55, 4'h7, 3'd5, 1'b0, 1'b1));
    chk(ctrl_rdata[30:0] == word(8'h05, 4'h0, 3'd2, 1'b1, 1'b0),
        "R8 fields held", ctrl_rdata[30:0], word(8'h05, 4'h0, 3'd2, 1'b1, 1'b0));
    wait_end();
    clear_all();

    // R7 abort, current try would match
    launch(8'h0F, 4'h0, 3'd4, 1'b1, 3);
    while (try_cnt < 3 || cs_n) @(negedge clk);
    push(3, 3'b001, "R7 abort over match");
    wr(word(8'h0F, 4'h0, 3'd4, 1'b1, 1'b0));
    wait_end();
    clear_all();

    // R7 abort in plain run
    launch(8'h11, 4'h2, 3'd0, 1'b1, 0);
    while (try_cnt < 5 || cs_n) @(negedge clk);
    push(5, 3'b001, "R7 abort");
    wr(word(8'h11, 4'h2, 3'd0, 1'b1, 1'b0));
    wait_end();
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1 && ctrl_rdata[31] == 1'b0, "R7 idle after abort", {cs_n, ctrl_rdata[31]}, 2'b10);
    clear_all();

    // R9 R6 set versus clear collision: ack held through a timeout run
    @(negedge clk);
    ack_we = 1'b1; ack = 3'b111;
    pulse0 = 0; pulse2 = 0;
    launch(8'h05, 4'h0, 3'd7, 1'b0, 0);
    push(31, 3'b101, "R9 set wins at end");
    wait_end();
    repeat (3) @(negedge clk);
    chk(pulse0 == 31, "R6 R9 try pulses under ack", pulse0, 31);
    chk(pulse2 == 1, "R9 timeout pulse under ack", pulse2, 1);
    chk(irq_stat == 3'b000, "R9 cleared after pulse", irq_stat, 0);
    ack_we = 1'b0; ack = 3'b000;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule